// File: doc/BRIEF.md
# Receive Event Statistics Counters

This block keeps two statistics counters for the receive side of a 100 Mb/s physical-layer receiver. It watches single-cycle status strobes from the receive symbol decoder. These strobes mark the opening of a frame, whether that frame began with a proper start-of-stream delimiter, a symbol error, a premature end of frame, and a normal frame end. From these strobes the block counts disconnect events and frames received with errors.

A frame that opens without its start delimiter counts as one disconnect. A frame that shows one or more error conditions counts exactly once in the error-frame counter, however many errors it contains. Both counters stop at their all-ones value instead of wrapping. A read returns a counter's value and clears that counter in the same step.

The read port is a plain strobe interface and has no back-pressure. The block accepts a read in any cycle that `rd_req` is high. The selected value appears on `rd_data` in the following cycle, with `rd_valid` high for that one cycle.

Top module: `rx_stat_counters`

## Requirements
- R1: After reset both counters read as zero and no frame is open.
- R2: The disconnect counter (read select 0) increments by one for each cycle with `frm_start` high and `frm_sd_ok` low. A start with `frm_sd_ok` high does not change it.
- R3: A frame that sees several error strobes adds exactly one to the error-frame counter (read select 1).
- R4: Both `sym_err` and `early_end` mark the open frame as errored. `early_end` also closes the frame, and a later `frm_end` then has no effect.
- R5: `frm_start` while a frame is open closes that frame, and counts it if it is errored, before it opens the new frame. Error strobes in that same cycle belong to the old frame.
- R6: Error strobes while no frame is open are ignored.
- R7: A counter at 65535 stays at 65535 on further events and never wraps to zero.
- R8: `rd_req` with `rd_sel` returns the selected counter's value on `rd_data` one cycle later, with `rd_valid` high, and clears that counter.
- R9: When a read and an increment of the same counter fall in one cycle, the read returns the value before the increment and the counter is left at 1.
- R10: A frame that closes without any error strobe is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | Frame begins this cycle |
| frm_sd_ok | input | 1 | Start delimiter was valid (qualifies `frm_start`) |
| sym_err | input | 1 | Symbol error seen this cycle |
| early_end | input | 1 | Premature end of frame; error and frame close |
| frm_end | input | 1 | Normal frame end |
| rd_req | input | 1 | Read strobe |
| rd_sel | input | 1 | 0 = disconnect counter, 1 = error-frame counter |
| rd_data | output | 16 | Read value, valid when `rd_valid` is high |
| rd_valid | output | 1 | High in the cycle after `rd_req` |

## Verification
The assertions assume that each status strobe lasts one cycle. They also assume that `frm_sd_ok` matters only while `frm_start` is high, and that `rd_sel` is stable in the cycle of `rd_req`. Any combination of strobes in one cycle is legal, and the priorities in R4 and R5 resolve it. The random stimulus draws every strobe independently each cycle, including overlapping start, end and error strobes and error strobes outside frames. Reads are drawn the same way, so reads often coincide with increments.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef enum logic {
    SEL_DISC = 1'b0,
    SEL_ERRF = 1'b1
  } cnt_sel_e;

  typedef struct packed {
    logic errf;
    logic disc;
  } evt_s;
endpackage

// File: rtl/rxs_frame_tracker.sv
module rxs_frame_tracker
  import rxs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frm_start,
  input  logic frm_sd_ok,
  input  logic sym_err,
  input  logic early_end,
  input  logic frm_end,
  output evt_s evt
);
  logic open_q, err_q;
  logic err_now, close_now;

  // errors only count while a frame is open
  assign err_now   = open_q & (sym_err | early_end);
  // a frame closes on normal end, premature end, or a restart
  assign close_now = open_q & (frm_end | early_end | frm_start);

  assign evt.disc = frm_start & ~frm_sd_ok;
  assign evt.errf = close_now & (err_q | err_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      open_q <= frm_start | (open_q & ~(frm_end | early_end));
      if (frm_start || close_now) err_q <= 1'b0;
      else                        err_q <= err_q | err_now;
    end
  end

  AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q |-> !err_q);                                        // R6
  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> open_q);                                      // R5
  AST_EARLY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (early_end && !frm_start) |=> !open_q);                     // R4
endmodule

// File: rtl/rxs_sat_counter.sv
module rxs_sat_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= inc ? ONE : '0;
    else if (inc && cnt != MAXV) cnt <= cnt + ONE;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXV && !clr) |=> cnt == MAXV);                     // R7
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc) |=> cnt == '0);                               // R8
  AST_READ_KEEPS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && inc) |=> cnt == ONE);                               // R9
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && cnt != MAXV) |=> cnt == $past(cnt) + ONE);  // R2
endmodule

// File: rtl/rx_stat_counters.sv
module rx_stat_counters
  import rxs_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_start,
  input  logic          frm_sd_ok,
  input  logic          sym_err,
  input  logic          early_end,
  input  logic          frm_end,
  input  logic          rd_req,
  input  logic          rd_sel,
  output logic [CW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int NCNT = 2;

  evt_s          evt;
  logic [NCNT-1:0] inc_v, clr_v;
  logic [CW-1:0] cnt_v [NCNT];

  rxs_frame_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_sd_ok(frm_sd_ok),
    .sym_err(sym_err), .early_end(early_end), .frm_end(frm_end), .evt(evt)
  );

  assign inc_v[SEL_DISC] = evt.disc;
  assign inc_v[SEL_ERRF] = evt.errf;

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    assign clr_v[i] = rd_req && (rd_sel == 1'(i));
    rxs_sat_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc_v[i]), .clr(clr_v[i]), .cnt(cnt_v[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= cnt_v[rd_sel];
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);                                       // R8
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (!rd_valid && $stable(rd_data)));               // R8
endmodule

// File: tb/sim_rx_stat_counters.sv
`timescale 1ns/1ps
module sim_rx_stat_counters;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_start = 0, frm_sd_ok = 0, sym_err = 0, early_end = 0, frm_end = 0;
  logic rd_req = 0, rd_sel = 0;
  logic [15:0] rd_data;
  logic rd_valid;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_disc = 0, m_err = 0;
  logic m_open = 0, m_flag = 0;

  always #10 clk = ~clk;

  rx_stat_counters u0 (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_sd_ok(frm_sd_ok),
    .sym_err(sym_err), .early_end(early_end), .frm_end(frm_end),
    .rd_req(rd_req), .rd_sel(rd_sel), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [15:0] upd(logic [15:0] v, logic inc, logic clr);
    if (clr) return inc ? 16'd1 : 16'd0;
    if (inc && v != 16'hFFFF) return v + 16'd1;
    return v;
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic sd, input logic se, input logic ee,
                      input logic fe, input logic rq, input logic sl, input string tag);
    logic [15:0] expv;
    logic err_now, close, bump;
    frm_start = s; frm_sd_ok = sd; sym_err = se; early_end = ee; frm_end = fe;
    rd_req = rq; rd_sel = sl;
    expv    = sl ? m_err : m_disc;
    err_now = (se | ee) & m_open;
    close   = m_open & (fe | ee | s);
    bump    = close & (m_flag | err_now);
    m_flag  = (s | close) ? 1'b0 : (m_flag | err_now);
    m_open  = s | (m_open & ~(fe | ee));
    m_disc  = upd(m_disc, s & ~sd, rq & ~sl);
    m_err   = upd(m_err, bump, rq & sl);
    @(negedge clk);
    if (rq) begin
      chk(rd_data, expv, tag);
      chk({15'd0, rd_valid}, 16'd1, {tag, " valid"});
    end
  endtask

  task automatic idle(); step(0,0,0,0,0,0,0,""); endtask

  task automatic rd(input logic sl, input logic [15:0] lit, input string tag);
    step(0,0,0,0,0,1,sl,tag);
    chk(rd_data, lit, {tag, " literal"});
  endtask

  initial begin
    #(20.0 * 250000);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(rd_data, 16'd0, "R1 rd_data at reset");
    chk({15'd0, rd_valid}, 16'd0, "R1 rd_valid at reset");
    rd(0, 16'd0, "R1 disc");
    rd(1, 16'd0, "R1 errf");
    // R2 disconnects
    step(1,0,0,0,0,0,0,""); step(1,0,0,0,0,0,0,""); step(1,0,0,0,0,0,0,"");
    step(1,1,0,0,0,0,0,"");
    step(0,0,0,0,1,0,0,"");
    rd(0, 16'd3, "R2 disc count");
    // R3 several errors in one frame
    step(1,1,0,0,0,0,0,"");
    step(0,0,1,0,0,0,0,""); step(0,0,1,0,0,0,0,""); step(0,0,1,0,0,0,0,"");
    step(0,0,0,0,1,0,0,"");
    rd(1, 16'd1, "R3 one per frame");
    // R4 early end closes and errs; later frm_end ignored
    step(1,1,0,0,0,0,0,"");
    step(0,0,0,1,0,0,0,"");
    step(0,0,0,0,1,0,0,"");
    step(1,1,0,0,0,0,0,"");
    step(0,0,1,0,0,0,0,"");
    step(0,0,0,1,0,0,0,"");
    rd(1, 16'd2, "R4 early end");
    // R10 clean frame
    step(1,1,0,0,0,0,0,""); idle(); step(0,0,0,0,1,0,0,"");
    rd(1, 16'd0, "R10 clean frame");
    // R6 errors outside frame
    step(0,0,1,0,0,0,0,""); step(0,0,0,1,0,0,0,""); step(0,0,1,1,0,0,0,"");
    rd(1, 16'd0, "R6 idle errors");
    // R5 restart closes old frame
    step(1,1,0,0,0,0,0,"");
    step(0,0,1,0,0,0,0,"");
    step(1,1,0,0,0,0,0,"");
    step(0,0,0,0,1,0,0,"");
    step(1,1,0,0,0,0,0,"");
    step(1,1,1,0,0,0,0,"");
    step(0,0,0,0,1,0,0,"");
    rd(1, 16'd2, "R5 restart close");
    // R9 read with increment
    step(1,0,0,0,0,0,0,""); step(1,0,0,0,0,0,0,"");
    step(1,0,0,0,0,1,0,"R9 disc same-cycle");
    chk(rd_data, 16'd2, "R9 disc pre-increment");
    rd(0, 16'd1, "R9 disc left at one");
    step(0,0,0,0,1,0,0,"");
    step(1,1,0,0,0,0,0,""); step(0,0,1,0,0,0,0,"");
    step(0,0,0,0,1,1,1,"R9 errf same-cycle");
    chk(rd_data, 16'd0, "R9 errf pre-increment");
    rd(1, 16'd1, "R9 errf left at one");
    // R7 saturation
    for (int k = 0; k < 65540; k++) step(1,0,0,0,0,0,0,"");
    step(0,0,0,0,1,0,0,"");
    rd(0, 16'hFFFF, "R7 saturated");
    rd(0, 16'd0, "R8 cleared after read");
    // random mix
    for (int k = 0; k < 5000; k++) begin
      step($urandom_range(0,99) < 15, $urandom_range(0,99) < 70,
           $urandom_range(0,99) < 10, $urandom_range(0,99) < 4,
           $urandom_range(0,99) < 12, $urandom_range(0,99) < 20,
           1'($urandom_range(0,1)), "R8 R3 random");
    end
    idle();
    rd(0, m_disc, "R8 final disc");
    rd(1, m_err, "R8 final errf");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule